// File: doc/BRIEF.md
# Periodic tick timer with cascaded watchdog

This block combines a periodic interrupt source and a watchdog on a small 16-bit register bus. A single-cycle prescaler enable pulse advances a down-counting divider chain of three stages: a fixed divide-by-8 stage, a divide-by-1-or-4 stage and a programmable divide-by-2-to-256 stage. Each time the chain wraps it raises a tick. The tick sets a sticky status flag, which may drive an interrupt line. The same tick also clocks a small watchdog down-counter.

Software programs the rates through a control register and can read the live chain value from a count register. It keeps the watchdog from expiring by writing a two-word key sequence to a service register. If the watchdog runs out, the block emits a fixed-length reset request and returns to its reset state. A debug-halt input freezes both counters, so that breakpoints do not trip the watchdog.

Register addresses: 0 is control, 1 is count (read-only), 2 is service (write-only, reads 0). Control layout: bit 15 is the status flag, bit 14 reads 0, bit 13 is the module enable, bit 12 the interrupt enable, bit 11 the watchdog enable, bit 10 the long-timeout select, bits 9:8 the middle-stage select and bits 7:0 the programmable divisor value DV.

Top module: `tick_watchdog`

## Requirements
- R1: The tick period is 8 x P x N prescaler pulses. P is 1 when bits 9:8 are 00 and 4 for any other value. N is DV+1 for DV from 1 to 255, and 256 for DV = 0.
- R2: The count register reads {DV-stage value in bits 12:5, middle stage in bits 4:3, fixed stage in bits 2:0}, with bits 15:13 zero. It decrements by one per prescaler pulse, and only while the module enable is set.
- R3: While dbg_halt is high, prescaler pulses change neither the chain nor the watchdog count.
- R4: A tick sets the status flag (bit 15). tick_irq is high exactly while the flag and the interrupt enable (bit 12) are both set.
- R5: Writing control with bit 15 = 1 clears the flag. Writing it with bit 15 = 0 leaves the flag unchanged.
- R6: With the module and watchdog enables both set, the watchdog expires on the 7th tick (bit 10 = 0) or the 63rd tick (bit 10 = 1). The count starts when a control write enables the watchdog, or at the last service. Expiry drives wdog_rst high for exactly 16 clocks.
- R7: A write of 0x5555 to the service register followed by a write of 0xAAAA reloads the watchdog and the chain. A 0xAAAA write without a preceding 0x5555, or after any other intervening service write, has no effect.
- R8: A control write stores bits 13:0 (bit 14 reads back 0) and reloads the chain from the newly written divider fields.
- R9: On expiry, control, flag and chain return to their reset values. Bus writes are ignored while wdog_rst is high.
- R10: After reset, control reads 0x0000, count reads 0x1FE7, and tick_irq and wdog_rst are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| presc_en | input | 1 | One-cycle prescaler pulse that advances the chain |
| dbg_halt | input | 1 | Freezes all counting while high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| tick_irq | output | 1 | Periodic interrupt request |
| wdog_rst | output | 1 | Watchdog reset request pulse |

## Verification
A wrong chain state shows up on the count register in the same cycle, and shows up as a misplaced flag edge within one tick period. A wrong watchdog count is invisible until it reaches expiry. It then shows as a wdog_rst edge that comes early or late, by a whole number of tick periods. The bench therefore checks expiry timing with exact pulse counts, both around services and around a debug-halt window. A broken key detector shows only through a missed or extra reload, so wrong key sequences are followed all the way to the expiry they must not prevent.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 2;
  localparam int SC_W   = 3;   // fixed divide-by-8 stage
  localparam int PRE_W  = 2;   // divide-by-1 or divide-by-4 stage
  localparam int DIV_W  = 8;   // programmable stage
  localparam int CNT_W  = SC_W + PRE_W + DIV_W;

  typedef struct packed {
    logic             mod_en;
    logic             irq_en;
    logic             wd_en;
    logic             wd_long;
    logic [1:0]       pre_sel;
    logic [DIV_W-1:0] dv;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // middle stage: select 0 passes straight through, anything else divides by 4
  function automatic logic [PRE_W-1:0] pre_reload(input logic [1:0] sel);
    return (sel == 2'd0) ? '0 : '1;
  endfunction

  // programmable stage divides by dv+1; dv of zero stands for the full 256
  function automatic logic [DIV_W-1:0] div_reload(input logic [DIV_W-1:0] dv);
    return (dv == '0) ? '1 : dv;
  endfunction
endpackage

// File: rtl/tw_chain.sv
module tw_chain
  import tw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic             hold_tick,
  input  ctrl_t            cur,
  input  ctrl_t            ld,
  output logic             tick,
  output logic [CNT_W-1:0] cnt
);
  logic [SC_W-1:0]  sc_q;
  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;

  wire sc_wrap  = step && (sc_q == '0);
  wire pre_wrap = sc_wrap && (pre_q == '0);
  wire div_wrap = pre_wrap && (div_q == '0);

  assign tick = div_wrap && !hold_tick;
  assign cnt  = {div_q, pre_q, sc_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_q  <= '1;
      pre_q <= '0;
      div_q <= '1;
    end else if (load) begin
      sc_q  <= '1;
      pre_q <= pre_reload(ld.pre_sel);
      div_q <= div_reload(ld.dv);
    end else if (step) begin
      sc_q <= sc_q - 1'b1;
      if (sc_wrap)
        pre_q <= (pre_q == '0) ? pre_reload(cur.pre_sel) : pre_q - 1'b1;
      if (pre_wrap)
        div_q <= (div_q == '0) ? div_reload(cur.dv) : div_q - 1'b1;
    end
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(cnt));
endmodule

// File: rtl/tw_guard.sv
module tw_guard #(
  parameter int SHORT_TO  = 7,
  parameter int LONG_TO   = 63,
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic running,
  input  logic wd_long,
  input  logic reload,
  input  logic reload_long,
  input  logic svc_ok,
  input  logic tick_i,
  output logic expire,
  output logic pulse_active
);
  localparam int WD_W = $clog2(LONG_TO + 1);
  localparam int PL_W = $clog2(PULSE_LEN + 1);

  logic [WD_W-1:0] wd_q;
  logic [PL_W-1:0] pl_q;

  function automatic logic [WD_W-1:0] start_of(input logic lng);
    return lng ? WD_W'(LONG_TO) : WD_W'(SHORT_TO);
  endfunction

  assign expire       = running && tick_i && !svc_ok && (wd_q == WD_W'(1));
  assign pulse_active = (pl_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_q <= WD_W'(SHORT_TO);
      pl_q <= '0;
    end else begin
      if (reload)       wd_q <= start_of(reload_long);
      else if (!running) wd_q <= start_of(wd_long);
      else if (tick_i)  wd_q <= wd_q - 1'b1;

      if (expire)            pl_q <= PL_W'(PULSE_LEN);
      else if (pl_q != '0)   pl_q <= pl_q - 1'b1;
    end
  end

  // R6
  wd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_active |-> !running);
  // R6
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_active) |-> $past(tick_i));
endmodule

// File: rtl/tw_regs.sv
module tw_regs
  import tw_pkg::*;
#(
  parameter logic [ADDR_W-1:0] A_CTRL = 2'd0,
  parameter logic [ADDR_W-1:0] A_CNT  = 2'd1,
  parameter logic [ADDR_W-1:0] A_SVC  = 2'd2,
  parameter logic [DATA_W-1:0] KEY_A  = 16'h5555,
  parameter logic [DATA_W-1:0] KEY_B  = 16'hAAAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              tick_i,
  input  logic              expire_i,
  input  logic              pulse_active,
  output ctrl_t             ctrl,
  output logic              flag,
  output logic              svc_ok,
  output logic              bus_load,
  output logic              chain_load,
  output logic              wd_reload,
  output ctrl_t             ld,
  output logic [DATA_W-1:0] rdata
);
  logic armed;

  wire we      = bus_wr && !pulse_active;
  wire ctrl_wr = we && (bus_addr == A_CTRL);
  wire svc_wr  = we && (bus_addr == A_SVC);
  wire wd_run  = ctrl.mod_en && ctrl.wd_en;

  assign svc_ok     = svc_wr && armed && (bus_wdata == KEY_B);
  assign bus_load   = ctrl_wr || svc_ok;
  assign chain_load = bus_load || expire_i;
  assign wd_reload  = svc_ok || expire_i || (ctrl_wr && !wd_run);

  always_comb begin
    if (expire_i)     ld = '0;
    else if (ctrl_wr) ld = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    else              ld = ctrl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (expire_i) begin
      ctrl  <= '0;
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      if (tick_i)                                flag <= 1'b1;
      else if (ctrl_wr && bus_wdata[DATA_W-1])   flag <= 1'b0;
      if (svc_wr) armed <= (bus_wdata == KEY_A);
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  rdata = {flag, {(DATA_W-CTRL_W-1){1'b0}}, ctrl};
      A_CNT:   rdata = {{(DATA_W-CNT_W){1'b0}}, cnt};
      default: rdata = '0;
    endcase
  end

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !expire_i) |=> flag);
  // R5
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && bus_wdata[DATA_W-1] && !tick_i) |=> !flag);
  // R9
  expiry_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(expire_i) |-> (ctrl == '0 && !flag));
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import tw_pkg::*;
#(
  parameter int SHORT_TO  = 7,
  parameter int LONG_TO   = 63,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              presc_en,
  input  logic              dbg_halt,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              tick_irq,
  output logic              wdog_rst
);
  ctrl_t            ctrl, ld;
  logic             flag, svc_ok, bus_load, chain_load, wd_reload;
  logic             tick, expire, pulse_active;
  logic [CNT_W-1:0] cnt;

  wire step    = presc_en && ctrl.mod_en && !dbg_halt;
  wire running = ctrl.mod_en && ctrl.wd_en;

  tw_regs u_regs (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .cnt,
    .tick_i(tick), .expire_i(expire), .pulse_active,
    .ctrl, .flag, .svc_ok, .bus_load, .chain_load, .wd_reload, .ld,
    .rdata(bus_rdata)
  );

  tw_chain u_chain (
    .clk, .rst_n, .step, .load(chain_load), .hold_tick(bus_load),
    .cur(ctrl), .ld, .tick, .cnt
  );

  tw_guard #(.SHORT_TO(SHORT_TO), .LONG_TO(LONG_TO), .PULSE_LEN(PULSE_LEN)) u_guard (
    .clk, .rst_n, .running, .wd_long(ctrl.wd_long),
    .reload(wd_reload), .reload_long(ld.wd_long), .svc_ok,
    .tick_i(tick), .expire, .pulse_active
  );

  assign tick_irq = flag && ctrl.irq_en;
  assign wdog_rst = pulse_active;

  // R3
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_halt && !chain_load) |=> $stable(cnt));
endmodule

// File: tb/tick_watchdog_test.sv
module tick_watchdog_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        presc_en = 1'b0;
  logic        dbg_halt = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd1;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        tick_irq, wdog_rst;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  tick_watchdog uut (
    .clk, .rst_n, .presc_en, .dbg_halt, .bus_wr, .bus_addr, .bus_wdata,
    .bus_rdata, .tick_irq, .wdog_rst
  );

  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  int m_ctrl, m_flag, m_arm, m_pos, m_wd, m_pul;
  bit m_ready = 0;
  int we, cw, sw, ok, en, stp, tk, run, ex;

  function automatic int per(int c);
    int n = ((c & 255) == 0) ? 256 : (c & 255) + 1;
    int p = (((c >> 8) & 3) != 0) ? 4 : 1;
    return 8 * p * n;
  endfunction

  function automatic int enc(int c, int pos);
    int p = (((c >> 8) & 3) != 0) ? 4 : 1;
    return ((pos / (8 * p)) << 5) | (((pos / 8) % p) << 3) | (pos % 8);
  endfunction

  function automatic int wstart(int c);
    return ((c >> 10) & 1) ? 63 : 7;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_flag = 0; m_arm = 0; m_pos = per(0) - 1; m_wd = 7; m_pul = 0;
      m_ready = 1;
    end else begin
      we  = (bus_wr && m_pul == 0) ? 1 : 0;
      cw  = (we && bus_addr == 2'd0) ? 1 : 0;
      sw  = (we && bus_addr == 2'd2) ? 1 : 0;
      ok  = (sw && m_arm && bus_wdata == 16'hAAAA) ? 1 : 0;
      en  = (m_ctrl >> 13) & 1;
      run = en & ((m_ctrl >> 11) & 1);
      stp = (presc_en && en && !dbg_halt) ? 1 : 0;
      tk  = (stp && m_pos == 0 && !cw && !ok) ? 1 : 0;
      ex  = (run && tk && m_wd == 1) ? 1 : 0;
      if (ex) begin
        m_ctrl = 0; m_flag = 0; m_arm = 0; m_pos = per(0) - 1; m_wd = 7; m_pul = 16;
      end else begin
        if (m_pul > 0) m_pul = m_pul - 1;
        if (ok || (cw && !run)) m_wd = wstart(cw ? int'(bus_wdata) : m_ctrl);
        else if (!run) m_wd = wstart(m_ctrl);
        else if (tk) m_wd = m_wd - 1;
        if (cw) m_pos = per(int'(bus_wdata)) - 1;
        else if (ok) m_pos = per(m_ctrl) - 1;
        else if (stp) m_pos = (m_pos == 0) ? per(m_ctrl) - 1 : m_pos - 1;
        if (tk) m_flag = 1;
        else if (cw && bus_wdata[15]) m_flag = 0;
        if (sw) m_arm = (bus_wdata == 16'h5555) ? 1 : 0;
        if (cw) m_ctrl = int'(bus_wdata) & 16'h3FFF;
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_ready && rst_n) begin
      if (bus_addr == 2'd1) chk("R2 count model", int'(bus_rdata), enc(m_ctrl, m_pos));
      else if (bus_addr == 2'd0) chk("R8 control model", int'(bus_rdata), (m_flag << 15) | m_ctrl);
      else chk("R8 service reads zero", int'(bus_rdata), 0);
      chk("R4 irq model", int'(tick_irq), (m_flag && ((m_ctrl >> 12) & 1)) ? 1 : 0);
      chk("R6 reset model", int'(wdog_rst), (m_pul != 0) ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(int n);
    presc_en = 1'b0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic pulses(int n);
    repeat (n) begin presc_en = 1'b1; @(posedge clk); #1; end
    presc_en = 1'b0;
  endtask

  task automatic gpulses(int n);
    repeat (n) begin
      presc_en = 1'b1; @(posedge clk); #1;
      presc_en = 1'b0; @(posedge clk); #1; @(posedge clk); #1;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = 2'd1;
  endtask

  task automatic peek(logic [1:0] a, string tag, int exp);
    bus_addr = a; #1;
    chk(tag, int'(bus_rdata), exp);
    bus_addr = 2'd1;
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R10 reset state
    peek(2'd0, "R10 control after reset", 16'h0000);
    peek(2'd1, "R10 count after reset", 16'h1FE7);
    chk("R10 irq after reset", int'(tick_irq), 0);
    chk("R10 wdog after reset", int'(wdog_rst), 0);

    // R1/R2: dv=2, /1 -> period 24
    wr(2'd0, 16'hB002);
    gpulses(5);
    peek(2'd1, "R2 count after 5 pulses", 16'h0042);
    // R3: halt freezes chain
    dbg_halt = 1'b1;
    gpulses(10);
    peek(2'd1, "R3 count frozen by halt", 16'h0042);
    dbg_halt = 1'b0;
    gpulses(18);
    peek(2'd0, "R1 no tick before period end", 16'h3002);
    gpulses(1);
    peek(2'd0, "R1 tick at period end sets flag", 16'hB002);
    chk("R4 irq with enable", int'(tick_irq), 1);

    // R2: module disabled holds the chain
    wr(2'd0, 16'h9002);
    peek(2'd1, "R8 reload on control write", 16'h0047);
    gpulses(5);
    peek(2'd1, "R2 disabled chain holds", 16'h0047);

    // R8: readback and reload from new fields (/4, dv=5)
    wr(2'd0, 16'hE105);
    peek(2'd0, "R8 bit14 reads zero", 16'h2105);
    peek(2'd1, "R8 chain reloaded from new fields", 16'h00BF);
    pulses(200);

    // R4/R5: flag without interrupt enable, then clear rules
    wr(2'd0, 16'hA001);
    pulses(16);
    peek(2'd0, "R4 flag set by tick", 16'hA001);
    chk("R4 irq masked", int'(tick_irq), 0);
    wr(2'd0, 16'h3001);
    peek(2'd0, "R5 write of zero keeps flag", 16'hB001);
    chk("R4 irq follows enable", int'(tick_irq), 1);
    wr(2'd0, 16'hB001);
    peek(2'd0, "R5 write of one clears flag", 16'h3001);

    // R6: short timeout, 7 ticks of 16 pulses
    wr(2'd0, 16'hA801);
    pulses(111);
    chk("R6 no reset before 7th tick", int'(wdog_rst), 0);
    pulses(1);
    for (int i = 0; i < 16; i++) begin
      chk("R6 reset pulse high", int'(wdog_rst), 1);
      if (i == 3) wr(2'd0, 16'h2000);
      else idle(1);
    end
    chk("R6 reset pulse ended", int'(wdog_rst), 0);
    peek(2'd0, "R9 control cleared, write during pulse ignored", 16'h0000);
    peek(2'd1, "R9 chain back to reset value", 16'h1FE7);

    // R7: valid service, then rejected sequences
    wr(2'd0, 16'hA801);
    pulses(100);
    wr(2'd2, 16'h5555);
    wr(2'd2, 16'hAAAA);
    pulses(100);
    chk("R7 service postponed expiry", int'(wdog_rst), 0);
    wr(2'd2, 16'hAAAA);
    wr(2'd2, 16'h5555);
    wr(2'd2, 16'h1234);
    wr(2'd2, 16'hAAAA);
    pulses(11);
    chk("R7 bad keys: not yet expired", int'(wdog_rst), 0);
    pulses(1);
    chk("R7 bad keys did not service", int'(wdog_rst), 1);
    idle(20);

    // R6/R3: long timeout with a halt window
    wr(2'd0, 16'hAC01);
    pulses(500);
    dbg_halt = 1'b1;
    pulses(50);
    dbg_halt = 1'b0;
    pulses(507);
    chk("R3 halt held watchdog, no early reset", int'(wdog_rst), 0);
    pulses(1);
    chk("R6 long timeout after 63 ticks", int'(wdog_rst), 1);
    idle(20);
    peek(2'd0, "R9 control cleared after long expiry", 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule